// File: doc/BRIEF.md
# Latency-Insensitive Shell Wrapper

This block wraps a stallable synchronous core so that the core tolerates any whole number of cycles of delay on its input channels. Every channel carries a data word and a flag. A raised flag marks the word as informative (a real value). A low flag marks a void token, which means the expected value has not arrived yet and will come in a later cycle. The wrapper waits until one informative token is ready for every input. It then fires the core for exactly one cycle and presents the core's result as an informative output token. In every other cycle the core's state is frozen by a clock enable and the output carries a void token.

Each input has a single-entry holding register with an occupied flag. A token that arrives early waits there until the slowest channel catches up. When the core fires, it takes the parked token of a channel if there is one, and the live input otherwise. The core is a registered accumulator that adds all input tokens into a running total. This makes the informative output stream easy to compare against an ideal core that sees no delays. There is no back-pressure, so an informative arrival at an occupied register that is not drained in that cycle is reported as an overflow.

Top module: `li_shell`

## Requirements
- R1: After reset all holding registers are empty and the running total is zero, so with all inputs void `out_valid` is 0.
- R2: `out_valid` is 1 in exactly those cycles in which every channel either holds a parked token or presents `in_valid`=1 (channel i uses bits i*DW and up of `in_data`).
- R3: In a firing cycle `out_data` equals the running total plus the sum of the consumed tokens, modulo 2^DW, and the running total takes that value at the next edge.
- R4: In a cycle that does not fire, `out_valid` is 0, `out_data` is 0 and the running total is left unchanged.
- R5: An informative token that arrives on a channel with an empty register in a cycle that does not fire is parked and consumed by a later firing.
- R6: When a channel has a parked token and also presents a live informative token in a firing cycle, the parked (older) token is consumed.
- R7: In a firing cycle a channel's register is emptied, unless a live informative token arrives on that channel in the same cycle, in which case that token is parked.
- R8: An informative arrival on a channel whose register is occupied, in a cycle that does not fire, raises `overflow` in that cycle. The arrival is discarded and the parked token is kept.
- R9: For any pattern of input stalls without overflow, the k-th informative output equals the k-th output of the same accumulator driven with no delays by the k-th token of every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NCH*DW | Input words, channel i in bits [i*DW +: DW] |
| in_valid | input | NCH | Per-channel informative flag |
| out_data | output | DW | Core result, zero when void |
| out_valid | output | 1 | Output informative flag (core fired) |
| overflow | output | 1 | Informative arrival dropped at an occupied register |

## Verification
The bench runs every sequence of three per-cycle valid masks over three channels. It follows these with a long pseudo-random stall pattern. Together they cover firing from live inputs only, from parked tokens only, and from mixes of both, with refills in the same cycle. Each output is checked twice: once against a cycle-level expectation derived from R2 to R8, and once against an undelayed reference accumulator fed the k-th token of each channel. The second check separates ordering or loss errors from simple timing errors. Directed sequences force an overflow and a parked-versus-live choice, so the discarded token and the consumption order can be seen in the output value.

// File: rtl/li_shell.sv
module li_shell #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [NCH-1:0]   in_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_valid,
  output logic             overflow
);

  logic [NCH-1:0] hold_full;
  logic [DW-1:0]  hold_data [NCH];
  logic [DW-1:0]  acc_q;
  logic [DW-1:0]  tok_sum;
  logic           fire;

  assign fire = &(hold_full | in_valid);

  always_comb begin
    tok_sum = '0;
    for (int i = 0; i < NCH; i++)
      tok_sum = tok_sum + (hold_full[i] ? hold_data[i] : in_data[i*DW +: DW]);
  end

  assign out_valid = fire;
  assign out_data  = fire ? acc_q + tok_sum : '0;
  assign overflow  = !fire && |(hold_full & in_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (fire) acc_q <= acc_q + tok_sum;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_full[g] <= 1'b0;
        hold_data[g] <= '0;
      end else if (fire) begin
        hold_full[g] <= hold_full[g] & in_valid[g];
        if (hold_full[g] & in_valid[g]) hold_data[g] <= in_data[g*DW +: DW];
      end else if (in_valid[g] && !hold_full[g]) begin
        hold_full[g] <= 1'b1;
        hold_data[g] <= in_data[g*DW +: DW];
      end
    end
  end

endmodule

module li_shell_chk #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] in_valid,
  input logic           out_valid,
  input logic [DW-1:0]  out_data,
  input logic [NCH-1:0] hold_full,
  input logic [DW-1:0]  acc_q
);

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> acc_q == $past(acc_q));

  a_r3_total: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> acc_q == $past(out_data));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && !out_valid) |=> hold_full[g]);

    a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !in_valid[g]) |=> !hold_full[g]);
  end

endmodule

bind li_shell li_shell_chk #(.NCH(NCH), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .hold_full(hold_full), .acc_q(acc_q)
);

// File: tb/li_shell_test.sv
module li_shell_test;
  localparam int PERIOD = 10;
  localparam int NCH = 3;
  localparam int DW = 8;
  localparam int QD = 8192;

  logic clk = 0, rst_n = 0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH-1:0] in_valid = '0;
  logic [DW-1:0] out_data;
  logic out_valid, overflow;

  li_shell #(.NCH(NCH), .DW(DW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [NCH-1:0] mfull = '0;
  logic [DW-1:0] mdata [NCH];
  logic [DW-1:0] macc = '0, refacc = '0;
  logic [DW-1:0] q [NCH][QD];
  int wptr [NCH];
  int nfire = 0;
  int seq = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NCH-1:0] v_in, input logic allow_ovf);
    logic [NCH-1:0] v;
    logic [NCH*DW-1:0] d;
    logic fire, eovf;
    logic [DW-1:0] sum, rsum;
    v = v_in;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) d[i*DW +: DW] = 8'(seq * 37 + i * 91 + 5);
    seq++;
    fire = &(mfull | v);
    if (!fire && !allow_ovf) v = v & ~mfull;
    eovf = !fire && |(mfull & v);
    sum = '0;
    for (int i = 0; i < NCH; i++) sum = sum + (mfull[i] ? mdata[i] : d[i*DW +: DW]);
    in_valid = v;
    in_data = d;
    #1;
    check("R2", 32'(out_valid), 32'(fire));
    check(fire ? "R3" : "R4", 32'(out_data), fire ? 32'(8'(macc + sum)) : 0);
    check("R8", 32'(overflow), 32'(eovf));
    for (int i = 0; i < NCH; i++)
      if (v[i] && !(mfull[i] && !fire) && wptr[i] < QD) begin
        q[i][wptr[i]] = d[i*DW +: DW];
        wptr[i]++;
      end
    if (fire) begin
      rsum = '0;
      for (int i = 0; i < NCH; i++) rsum = rsum + q[i][nfire];
      refacc = refacc + rsum;
      nfire++;
      check("R9", 32'(out_data), 32'(refacc));
    end
    for (int i = 0; i < NCH; i++) begin
      if (fire) begin
        if (mfull[i] && v[i]) mdata[i] = d[i*DW +: DW];
        mfull[i] = mfull[i] & v[i];
      end else if (v[i] && !mfull[i]) begin
        mfull[i] = 1'b1;
        mdata[i] = d[i*DW +: DW];
      end
    end
    if (fire) macc = macc + sum;
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NCH; i++) begin wptr[i] = 0; mdata[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    check("R1", 32'(out_valid), 0);
    check("R1", 32'(out_data), 0);

    // R6, R7: park ch0, then fire with live ch0 too; next fire uses refilled ch0
    step(3'b001, 0);
    step(3'b111, 0);
    step(3'b110, 0);
    // R8: overflow on ch1, parked value survives
    step(3'b010, 0);
    step(3'b010, 1);
    step(3'b101, 0);

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          step(3'(a), 0);
          step(3'(b), 0);
          step(3'(c), 0);
        end

    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] | lfsr[5:3], lfsr[9:6] == 4'h0);
    end
    step(3'b111, 0);
    step(3'b111, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule